// File: doc/BRIEF.md
# Nearest-Level Gate State Selector for an 81-Level Inverter

This block drives the gates of a single-phase multilevel inverter built from four DC stages whose source voltages are in the ratio 1:3:9:27. Each stage can add its source, subtract it, or be bypassed. Together the stages reach every integer magnitude from 0 to 40 units of the smallest source. A polarity H-bridge then gives each magnitude a positive and a negative version. The result is 81 output levels: 40 positive, 40 negative and zero.

A controller presents a signed voltage reference sample with a one-cycle valid pulse. The reference is fixed point in units of the smallest source voltage, with `FRAC_W` fractional bits. The block takes the sample's magnitude and runs a binary search, one comparison per clock, over a sorted table of the 41 level voltages. The search finds the level nearest to that magnitude. The block then reads that level's stage switching vector and selects the bridge pattern from the sample's sign. A reduced modulation index simply keeps the reference small, so the top levels are never reached.

The stage gate outputs and a one-cycle done strobe update together when the search ends. The bridge never shorts a leg. It holds all four bridge gates off for one cycle whenever its operating mode changes.

Top module: `nls_selector`

## Requirements
- R1: With the reference magnitude m in fixed point (FRAC_W = 4, so one level equals 16 counts), the chosen level is the integer k in 0..40 nearest to m/16. An exact midpoint resolves to the lower level (m = 8 gives 0, m = 24 gives 1).
- R2: A magnitude above level 40 selects level 40, including the most negative sample value (-2048 selects level 40 with negative polarity).
- R3: Stage gates use two bits per stage i (weight 3^i): bit 2i inserts the source adding +3^i, bit 2i+1 inserts it subtracting 3^i, and 00 bypasses it. Both bits of a stage are never high together. The signed weighted sum of the stage gates equals the chosen level.
- R4: Bridge gate bits are [3] leg A high side, [2] leg A low side, [1] leg B high side, [0] leg B low side. A non-zero level with a non-negative reference drives 4'b1001. A non-zero level with a negative reference drives 4'b0110.
- R5: Level zero drives the freewheel pattern 4'b0101 (both low sides on), whatever the sign of the reference.
- R6: No leg ever has both of its devices on. When the bridge mode (off, positive, negative, freewheel) differs from the one held, the bridge gates are 4'b0000 for the cycle that follows the done edge, and the new pattern appears one cycle later. When the mode is unchanged, the bridge gates do not change. The mode held after reset is off.
- R7: A sample accepted at clock edge E0 raises done for exactly one cycle after edge E6 (six search steps). The stage gates change only together with done.
- R8: A valid sample presented while a search is in progress is ignored. It produces no extra done pulse and does not alter the result being computed.
- R9: During and right after reset, all stage and bridge gates are 0 and done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_valid | input | 1 | One-cycle strobe marking a new reference sample |
| ref_sample | input | SAMPLE_W | Signed fixed-point reference, FRAC_W fractional bits |
| stage_gates | output | 2*NSTAGE | Per-stage add/subtract gate pairs |
| bridge_gates | output | 4 | Polarity bridge gates {A high, A low, B high, B low} |
| done | output | 1 | One-cycle pulse when the new gate state is applied |

## Verification
A wrong search bound or step count shows up at the ports in the done cycle. Either the stage gates decode to a level one off the nearest level, or done arrives a cycle early or late relative to acceptance. Each sample is therefore compared on every clock from acceptance to one cycle after done. A stale bridge mode register shows up in the cycle after done, as a missing or spurious all-off cycle or as the wrong leg pattern. Tie, clamp and sign-reversal samples expose these errors within eight cycles of the offending sample.

// File: rtl/nls_pkg.sv
// Package: shared types and elaboration-time helpers for the nearest-level
// selector. Assumes stage weights are successive powers of three.
package nls_pkg;

    typedef enum logic [1:0] {
        BR_OFF  = 2'd0,
        BR_POS  = 2'd1,
        BR_NEG  = 2'd2,
        BR_FREE = 2'd3
    } br_mode_e;

    // Integer power of three, used for level counts.
    function automatic int pow3(input int n);
        int acc;
        acc = 1;
        for (int i = 0; i < n; i++) acc = acc * 3;
        return acc;
    endfunction

    // Balanced-ternary digit of a level at one stage: 01 = +, 10 = -, 00 = bypass.
    function automatic logic [1:0] trit_code(input int lvl, input int stage);
        int v;
        int r;
        logic [1:0] code;
        v = lvl;
        code = 2'b00;
        for (int i = 0; i <= stage; i++) begin
            r = v % 3;
            if (r == 2) begin
                code = 2'b10;
                v = (v + 1) / 3;
            end else if (r == 1) begin
                code = 2'b01;
                v = (v - 1) / 3;
            end else begin
                code = 2'b00;
                v = v / 3;
            end
        end
        return code;
    endfunction

    // Bridge gate pattern {A_hi, A_lo, B_hi, B_lo} for a mode.
    function automatic logic [3:0] br_pattern(input br_mode_e m);
        case (m)
            BR_POS:  return 4'b1001;
            BR_NEG:  return 4'b0110;
            BR_FREE: return 4'b0101;
            default: return 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/nls_level_table.sv
// Module: computed level table. Holds the sorted level voltages (k << FRAC_W)
// and the balanced-ternary stage vector of each magnitude level 0..NPOS.
// Assumes index inputs stay within 0..NPOS; out-of-range reads return zero.
module nls_level_table #(
    parameter int NSTAGE = 4,
    parameter int NPOS   = 40,
    parameter int FRAC_W = 4,
    parameter int IDX_W  = 6,
    parameter int VAL_W  = 10
) (
    input  logic [IDX_W-1:0]    idx_mid,
    input  logic [IDX_W-1:0]    idx_below,
    input  logic [IDX_W-1:0]    idx_state,
    output logic [VAL_W-1:0]    lvl_mid,
    output logic [VAL_W-1:0]    lvl_below,
    output logic [2*NSTAGE-1:0] state_sel
);
    logic [VAL_W-1:0]    tbl_lvl   [NPOS+1];
    logic [2*NSTAGE-1:0] tbl_state [NPOS+1];

    // Build each table entry from its level index.
    for (genvar k = 0; k <= NPOS; k++) begin : g_entry
        localparam logic [VAL_W-1:0] LV = VAL_W'(k) << FRAC_W;
        assign tbl_lvl[k] = LV;
        for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
            assign tbl_state[k][2*i +: 2] = nls_pkg::trit_code(k, i);
        end
    end

    // Three combinational read ports.
    always_comb begin
        lvl_mid   = (int'(idx_mid)   <= NPOS) ? tbl_lvl[idx_mid]     : '0;
        lvl_below = (int'(idx_below) <= NPOS) ? tbl_lvl[idx_below]   : '0;
        state_sel = (int'(idx_state) <= NPOS) ? tbl_state[idx_state] : '0;
    end

endmodule

// File: rtl/nls_search.sv
// Module: sequential binary search for the nearest level. Finds the largest k
// with 2*mag > lvl[k] + lvl[k-1] (k = 0 always qualifies), which is nearest
// level with ties to the lower one and clamping at NPOS. Runs exactly STEPS
// steps per sample; new starts are ignored while busy.
module nls_search #(
    parameter int NPOS  = 40,
    parameter int IDX_W = 6,
    parameter int VAL_W = 10,
    parameter int MAG_W = 12,
    parameter int STEPS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [MAG_W-1:0] start_mag,
    input  logic [VAL_W-1:0] lvl_mid,
    input  logic [VAL_W-1:0] lvl_below,
    output logic [IDX_W-1:0] idx_mid,
    output logic [IDX_W-1:0] idx_below,
    output logic             busy,
    output logic             fin,
    output logic [IDX_W-1:0] fin_level
);
    localparam int CNT_W = $clog2(STEPS + 1);
    localparam int CMP_W = ((MAG_W > VAL_W) ? MAG_W : VAL_W) + 2;

    logic             busy_q;
    logic [IDX_W-1:0] lo_q, hi_q, lo_d, hi_d;
    logic [CNT_W-1:0] cnt_q;
    logic [MAG_W-1:0] mag_q;
    logic [IDX_W:0]   mid_sum;
    logic [CMP_W-1:0] twice_mag, thr;

    // Upper-middle probe index and its lower neighbour.
    always_comb begin
        mid_sum   = ({1'b0, lo_q} + {1'b0, hi_q} + (IDX_W+1)'(1)) >> 1;
        idx_mid   = mid_sum[IDX_W-1:0];
        idx_below = (idx_mid == '0) ? '0 : idx_mid - IDX_W'(1);
    end

    // One comparison step: move the bound that excludes the probe.
    always_comb begin
        lo_d      = lo_q;
        hi_d      = hi_q;
        twice_mag = CMP_W'({mag_q, 1'b0});
        thr       = CMP_W'(lvl_mid) + CMP_W'(lvl_below);
        if (lo_q < hi_q) begin
            if (twice_mag > thr) lo_d = idx_mid;
            else                 hi_d = idx_below;
        end
    end

    assign busy      = busy_q;
    assign fin       = busy_q && (cnt_q == CNT_W'(STEPS - 1));
    assign fin_level = lo_d;

    // Search state: load on start when idle, step while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            lo_q   <= '0;
            hi_q   <= '0;
            cnt_q  <= '0;
            mag_q  <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                lo_q   <= '0;
                hi_q   <= IDX_W'(NPOS);
                cnt_q  <= '0;
                mag_q  <= start_mag;
            end
        end else begin
            lo_q  <= lo_d;
            hi_q  <= hi_d;
            cnt_q <= cnt_q + CNT_W'(1);
            if (fin) busy_q <= 1'b0;
        end
    end

endmodule

// File: rtl/nls_bridge.sv
// Module: polarity bridge gate sequencer. Applies the pattern for a new mode;
// when the mode differs from the held one it outputs all-off for one cycle
// first. Assumes applies are at least two cycles apart.
module nls_bridge (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              apply,
    input  nls_pkg::br_mode_e apply_mode,
    output logic [3:0]        gates
);
    nls_pkg::br_mode_e held_q;
    logic              pend_q;

    // Mode hand-over with one idle cycle on any change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= nls_pkg::BR_OFF;
            pend_q <= 1'b0;
            gates  <= 4'b0000;
        end else if (apply) begin
            if (apply_mode != held_q) begin
                held_q <= apply_mode;
                pend_q <= 1'b1;
                gates  <= 4'b0000;
            end else begin
                gates  <= nls_pkg::br_pattern(apply_mode);
            end
        end else if (pend_q) begin
            pend_q <= 1'b0;
            gates  <= nls_pkg::br_pattern(held_q);
        end
    end

endmodule

// File: rtl/nls_selector.sv
// Module: top of the nearest-level gate state selector. Takes a signed
// fixed-point reference, searches the nearest magnitude level, and drives the
// stage gate vector plus the polarity bridge. Assumes ref_valid is a strobe.
module nls_selector #(
    parameter int NSTAGE   = 4,
    parameter int SAMPLE_W = 12,
    parameter int FRAC_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ref_valid,
    input  logic [SAMPLE_W-1:0] ref_sample,
    output logic [2*NSTAGE-1:0] stage_gates,
    output logic [3:0]          bridge_gates,
    output logic                done
);
    localparam int NLEV  = nls_pkg::pow3(NSTAGE);
    localparam int NPOS  = (NLEV - 1) / 2;
    localparam int IDX_W = $clog2(NPOS + 1);
    localparam int VAL_W = IDX_W + FRAC_W;
    localparam int STEPS = $clog2(NPOS + 1);

    logic [SAMPLE_W-1:0] mag_in;
    logic                sign_q;
    logic [IDX_W-1:0]    idx_mid, idx_below, fin_level;
    logic [VAL_W-1:0]    lvl_mid, lvl_below;
    logic [2*NSTAGE-1:0] state_sel;
    logic                busy, fin;
    nls_pkg::br_mode_e   mode_new;

    // Magnitude of the two's-complement reference.
    assign mag_in = ref_sample[SAMPLE_W-1] ? (~ref_sample + SAMPLE_W'(1)) : ref_sample;

    nls_level_table #(
        .NSTAGE(NSTAGE), .NPOS(NPOS), .FRAC_W(FRAC_W), .IDX_W(IDX_W), .VAL_W(VAL_W)
    ) u_table (
        .idx_mid(idx_mid), .idx_below(idx_below), .idx_state(fin_level),
        .lvl_mid(lvl_mid), .lvl_below(lvl_below), .state_sel(state_sel)
    );

    nls_search #(
        .NPOS(NPOS), .IDX_W(IDX_W), .VAL_W(VAL_W), .MAG_W(SAMPLE_W), .STEPS(STEPS)
    ) u_search (
        .clk(clk), .rst_n(rst_n), .start(ref_valid), .start_mag(mag_in),
        .lvl_mid(lvl_mid), .lvl_below(lvl_below),
        .idx_mid(idx_mid), .idx_below(idx_below),
        .busy(busy), .fin(fin), .fin_level(fin_level)
    );

    // Bridge mode from the final level and the latched sign.
    always_comb begin
        if (fin_level == '0) mode_new = nls_pkg::BR_FREE;
        else if (sign_q)     mode_new = nls_pkg::BR_NEG;
        else                 mode_new = nls_pkg::BR_POS;
    end

    nls_bridge u_bridge (
        .clk(clk), .rst_n(rst_n), .apply(fin), .apply_mode(mode_new),
        .gates(bridge_gates)
    );

    // Latch the sign of an accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n)                 sign_q <= 1'b0;
        else if (ref_valid && !busy) sign_q <= ref_sample[SAMPLE_W-1];
    end

    // Stage gates and done strobe update together at search completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_gates <= '0;
            done        <= 1'b0;
        end else begin
            done <= fin;
            if (fin) stage_gates <= state_sel;
        end
    end

endmodule

// File: rtl/nls_selector_chk.sv
// Module: port-level property checker for nls_selector, attached by bind.
// Assumes reset is held for at least two clock edges.
module nls_selector_chk #(
    parameter int NSTAGE = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2*NSTAGE-1:0] stage_gates,
    input logic [3:0]          bridge_gates,
    input logic                done
);
    // R6: one device per leg at most.
    p_leg_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bridge_gates[3] && bridge_gates[2]) && !(bridge_gates[1] && bridge_gates[0]));

    // R6: two consecutive active patterns must be equal.
    p_no_direct_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bridge_gates != 4'b0000 && $past(bridge_gates) != 4'b0000)
        |-> (bridge_gates == $past(bridge_gates)));

    // R7: done lasts one cycle.
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: stage gates change only in a done cycle.
    p_stage_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stage_gates) |-> done);

    // R5: a zero level ends in freewheel.
    p_zero_freewheel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && stage_gates == '0) |=> (bridge_gates == 4'b0101));

    // R4: a non-zero level ends in a driving pattern.
    p_nonzero_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && stage_gates != '0) |=> (bridge_gates == 4'b1001 || bridge_gates == 4'b0110));

    // R3: no stage adds and subtracts at once.
    for (genvar i = 0; i < NSTAGE; i++) begin : g_stage_chk
        p_stage_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !(stage_gates[2*i] && stage_gates[2*i+1]));
    end

endmodule

bind nls_selector nls_selector_chk #(.NSTAGE(NSTAGE)) u_chk (
    .clk(clk), .rst_n(rst_n), .stage_gates(stage_gates),
    .bridge_gates(bridge_gates), .done(done)
);

// File: tb/nls_selector_tb.sv
// Bench: behavioural model of nearest level, stage decode and bridge sequence,
// compared every clock from sample acceptance to one cycle after done.
module nls_selector_tb;
    localparam int FRAC     = 4;
    localparam int NTOP     = 40;
    localparam int WD_LIMIT = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_valid = 1'b0;
    logic [11:0] ref_sample = '0;
    logic [7:0]  stage_gates;
    logic [3:0]  bridge_gates;
    logic        done;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int prev_mode = 0;   // 0 off, 1 positive, 2 negative, 3 freewheel

    always #2.5 clk = ~clk;

    nls_selector u_dut (
        .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_sample(ref_sample),
        .stage_gates(stage_gates), .bridge_gates(bridge_gates), .done(done)
    );

    // Watchdog: a hung run is a failure.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_LIMIT) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: act=%0d exp=<%0d cycles", cyc, WD_LIMIT);
            $display("[TB] %0d tests run, %0d failed", n_checks + 1, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, expv);
        end
    endtask

    function automatic int nearest(input int s);
        int m, num, k;
        m = (s < 0) ? -s : s;
        num = 2 * m - (1 << FRAC);
        if (num <= 0) k = 0;
        else k = (num + (1 << (FRAC + 1)) - 1) / (1 << (FRAC + 1));
        if (k > NTOP) k = NTOP;
        return k;
    endfunction

    // Signed weighted sum of stage gates; -1000 flags an illegal 11 pair.
    function automatic int decode(input logic [7:0] g);
        int w, acc;
        w = 1; acc = 0;
        for (int i = 0; i < 4; i++) begin
            if (g[2*i] && g[2*i+1]) return -1000;
            if (g[2*i])   acc = acc + w;
            if (g[2*i+1]) acc = acc - w;
            w = w * 3;
        end
        return acc;
    endfunction

    function automatic logic [3:0] pat(input int mode);
        case (mode)
            1: return 4'b1001;
            2: return 4'b0110;
            3: return 4'b0101;
            default: return 4'b0000;
        endcase
    endfunction

    // Drive one sample, optionally a second one mid-search, and compare every cycle.
    task automatic run_one(input int s, input bit inject, input int inj_val);
        int k, mode;
        logic [7:0] stage_at_done;
        k = nearest(s);
        mode = (k == 0) ? 3 : ((s < 0) ? 2 : 1);
        @(negedge clk);
        ref_valid = 1'b1;
        ref_sample = 12'(s);
        @(negedge clk);          // after acceptance edge E0
        ref_valid = 1'b0;
        for (int j = 1; j <= 5; j++) begin
            if (inject && j == 2) begin
                ref_valid = 1'b1;
                ref_sample = 12'(inj_val);
            end
            @(negedge clk);      // after edge E_j
            ref_valid = 1'b0;
            check(done == 1'b0, "R7 done early", int'(done), 0);
        end
        @(negedge clk);          // after E6
        check(done == 1'b1, "R7 done at step six", int'(done), 1);
        check(decode(stage_gates) == k, "R1/R2/R3 level", decode(stage_gates), k);
        stage_at_done = stage_gates;
        if (mode != prev_mode)
            check(bridge_gates == 4'b0000, "R6 idle on mode change", int'(bridge_gates), 0);
        else
            check(bridge_gates == pat(mode), "R6 unchanged mode", int'(bridge_gates), int'(pat(mode)));
        @(negedge clk);          // after E7
        check(done == 1'b0, "R7 single pulse", int'(done), 0);
        if (mode == 3)
            check(bridge_gates == 4'b0101, "R5 freewheel", int'(bridge_gates), 5);
        else
            check(bridge_gates == pat(mode), "R4 polarity", int'(bridge_gates), int'(pat(mode)));
        check(stage_gates == stage_at_done, "R7 stage hold", int'(stage_gates), int'(stage_at_done));
        prev_mode = mode;
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            check(done == 1'b0, "R8 no extra done", int'(done), 0);
            check(bridge_gates == pat(mode), "R8 bridge kept", int'(bridge_gates), int'(pat(mode)));
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(stage_gates == '0, "R9 reset stage", int'(stage_gates), 0);
        check(bridge_gates == '0, "R9 reset bridge", int'(bridge_gates), 0);
        check(done == 1'b0, "R9 reset done", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(bridge_gates == '0 && done == 1'b0, "R9 after reset", int'(bridge_gates), 0);

        run_one(16, 0, 0);       // R4 level 1 positive, first apply from off
        run_one(32, 0, 0);       // R6 same mode, no idle
        run_one(8, 0, 0);        // R1 tie 0.5 -> 0, R5 freewheel
        run_one(24, 0, 0);       // R1 tie 1.5 -> 1
        run_one(25, 0, 0);       // R1 just above tie -> 2
        run_one(-16, 0, 0);      // R4 R6 reversal to negative
        run_one(-8, 0, 0);       // R5 zero with negative sign
        run_one(215, 0, 0);      // R1 13.4375 -> 13
        run_one(640, 0, 0);      // R2 exact top
        run_one(648, 0, 0);      // R2 tie above top clamps
        run_one(2047, 0, 0);     // R2 largest positive
        run_one(-2048, 0, 0);    // R2 most negative
        run_one(100, 1, 600);    // R8 second sample ignored
        run_one(-300, 1, 16);    // R8 ignored while negative search runs
        for (int k = 0; k <= NTOP; k++) run_one(k * 16, 0, 0);       // R3 every level
        for (int v = -700; v <= 700; v += 53) run_one(v, 0, 0);      // R1 sweep

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule